// File: doc/BRIEF.md
# Station-Address PROM Access Decoder

This block sits between the host bus and a network controller. It holds a 16-byte station-address store and decides, for every host access, whether the store serves it, whether it passes on to the controller's register port, or whether it is rejected. Accesses arrive from two windows: an I/O window and a memory-mapped window. Each access is 1, 2 or 4 bytes wide. In both windows, offset bit 4 picks the register half, and the low four offset bits index the store or form the port offset.

In the I/O window the store obeys a 16/32-bit I/O mode bit. In narrow mode it takes byte accesses anywhere and word accesses at even offsets. In wide mode it takes only dword accesses at 4-aligned offsets. The memory-mapped window always builds word and dword store accesses out of bytes. The register half of either window takes only words and dwords. A rejected read returns all-ones at the access width, and a rejected write is dropped. Multi-byte store data is little-endian. A separate write-enable bit guards the store against writes.

A configuration strobe loads the I/O mode bit and the store write-enable bit. Each request lasts one cycle and is qualified by a valid strobe. Read data comes back on the next cycle with a one-cycle valid pulse. The register port sees requests in the same cycle as the host and returns its read data combinationally.

Top module: `prom_access_decoder`

## Requirements
- R1: After reset the response valid is low and the I/O mode bit and the store write-enable bit are both 0. Store byte i holds bits [8i+7:8i] of the DEF_PROM parameter.
- R2: A store write takes effect only while the write-enable bit is 1. Store reads are allowed whatever that bit holds.
- R3: In the I/O window (req_mem = 0), offsets below 0x10 select the store and offsets 0x10 and above select the register port. The register half accepts only size codes 1 (word) and 2 (dword), at any offset. Size code 0 is byte and size code 3 is never legal.
- R4: With the I/O mode bit at 0, the I/O-window store half accepts byte accesses at every offset and word accesses at even offsets only. It rejects dwords.
- R5: With the I/O mode bit at 1, the I/O-window store half accepts only dword accesses at offsets whose two low bits are 0.
- R6: Multi-byte store data is little-endian. Lane k (bits [8k+7:8k]) carries store byte (offset + k) modulo 16. Lanes above the access width read as 0.
- R7: A rejected read returns 0xFF for size 0, 0xFFFF for size 1 and 0xFFFFFFFF for sizes 2 and 3, with the higher bits 0. A rejected write changes nothing and reaches no port.
- R8: In the memory-mapped window (req_mem = 1), bit 4 selects the register port and otherwise the store. The store half accepts sizes 0, 1 and 2 at any offset, whatever the I/O mode, and composes them from bytes as in R6. The register half rejects bytes.
- R9: A read request is answered by rsp_valid high for exactly the next cycle, with rsp_rdata valid. A write request produces no response.
- R10: An accepted register-half access drives rp_valid in the same cycle, with rp_addr equal to the low four offset bits, rp_dword high for size 2 and the write data passed through. The response carries rp_rdata masked to the access width.
- R11: A cycle with cfg_load high loads cfg_io32 into the I/O mode bit and cfg_prom_we into the write-enable bit. The new values govern requests from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Load the mode bits this cycle |
| cfg_io32 | input | 1 | New I/O mode bit (1 = 32-bit) |
| cfg_prom_we | input | 1 | New store write-enable bit |
| req_valid | input | 1 | Host request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory-mapped window, 0 = I/O window |
| req_addr | input | 5 | Window offset; bit 4 selects the register half |
| req_size | input | 2 | 0 byte, 1 word, 2 dword, 3 illegal |
| req_wdata | input | 32 | Write data, little-endian lanes |
| rsp_valid | output | 1 | Read response pulse |
| rsp_rdata | output | 32 | Read response data |
| rp_valid | output | 1 | Register-port request |
| rp_write | output | 1 | Register-port write |
| rp_addr | output | 4 | Register-port offset |
| rp_dword | output | 1 | 1 = dword, 0 = word |
| rp_wdata | output | 32 | Register-port write data |
| rp_rdata | input | 32 | Register-port read data, valid while rp_valid |

## Verification
The assertions assume that requests change only between clock edges and that rp_rdata is settled whenever rp_valid is high. They also assume that no configuration load and no request ever look at one another's effect in the same cycle. The stimulus drives every input on the falling edge and issues at most one operation every two cycles. It changes modes only through a separate load cycle between request sweeps. The bench's register-port model is a pure function of rp_addr, so the port data is known and stable at every sampling point.

// File: rtl/prom_dec_pkg.sv
package prom_dec_pkg;

    localparam int BYTE_W = 8;
    localparam int LANES  = 4;
    localparam int DATA_W = BYTE_W * LANES;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_BAD   = 2'd3
    } acc_size_e;

    // Response / mode state of the top level
    typedef struct packed {
        logic              rsp_valid;
        logic [DATA_W-1:0] rsp_rdata;
        logic              io32;
        logic              prom_we;
    } ctl_state_t;

endpackage

// File: rtl/prom_dec_decode.sv
module prom_dec_decode
    import prom_dec_pkg::*;
#(
    parameter int OFS_W = 4
) (
    input  logic                 space_mem,
    input  logic                 io32,
    input  logic [OFS_W:0]       addr,
    input  logic [1:0]           size,
    output logic                 sel_port,
    output logic                 legal,
    output logic [LANES-1:0]     lane_en,
    output logic [DATA_W-1:0]    width_ones
);

    acc_size_e sz;

    always_comb begin
        sz       = acc_size_e'(size);
        sel_port = addr[OFS_W];

        case (sz)
            SZ_BYTE: begin
                lane_en    = 4'b0001;
                width_ones = 32'h0000_00FF;
            end
            SZ_WORD: begin
                lane_en    = 4'b0011;
                width_ones = 32'h0000_FFFF;
            end
            default: begin
                lane_en    = 4'b1111;
                width_ones = 32'hFFFF_FFFF;
            end
        endcase

        if (sel_port) begin
            legal = (sz == SZ_WORD) || (sz == SZ_DWORD);
        end else if (space_mem) begin
            legal = (sz != SZ_BAD);
        end else if (io32) begin
            legal = (sz == SZ_DWORD) && (addr[1:0] == 2'b00);
        end else begin
            legal = (sz == SZ_BYTE) || ((sz == SZ_WORD) && !addr[0]);
        end
    end

endmodule

// File: rtl/prom_dec_store.sv
module prom_dec_store
    import prom_dec_pkg::*;
#(
    parameter int OFS_W = 4,
    parameter logic [BYTE_W*(2**OFS_W)-1:0] DEF_PROM = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [OFS_W-1:0]     base,
    input  logic [LANES-1:0]     lane_en,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata
);

    localparam int DEPTH = 2 ** OFS_W;

    typedef struct packed {
        logic [DEPTH-1:0][BYTE_W-1:0] bytes;
    } store_t;

    store_t st_d, st_q;
    logic [OFS_W-1:0] idx [LANES];

    // One byte lane per slot, index wraps modulo the store depth
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign idx[k] = base + OFS_W'(k);
        assign rdata[BYTE_W*k +: BYTE_W] =
            lane_en[k] ? st_q.bytes[idx[k]] : '0;
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < DEPTH; i++) begin
            for (int k = 0; k < LANES; k++) begin
                if (wr_en && lane_en[k] && (idx[k] == OFS_W'(i))) begin
                    st_d.bytes[i] = wdata[BYTE_W*k +: BYTE_W];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.bytes <= DEF_PROM;
        end else begin
            st_q <= st_d;
        end
    end

    // R2
    prom_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q.bytes));

endmodule

// File: rtl/prom_access_decoder.sv
module prom_access_decoder
    import prom_dec_pkg::*;
#(
    parameter int OFS_W = 4,
    parameter logic [BYTE_W*(2**OFS_W)-1:0] DEF_PROM =
        128'h0F0E_0D0C_0B0A_0908_5757_A1B2_C3D4_0052
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic              cfg_io32,
    input  logic              cfg_prom_we,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_mem,
    input  logic [OFS_W:0]    req_addr,
    input  logic [1:0]        req_size,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              rp_valid,
    output logic              rp_write,
    output logic [OFS_W-1:0]  rp_addr,
    output logic              rp_dword,
    output logic [31:0]       rp_wdata,
    input  logic [31:0]       rp_rdata
);

    ctl_state_t ctl_d, ctl_q;

    logic              dec_port;
    logic              dec_legal;
    logic [LANES-1:0]  dec_lanes;
    logic [DATA_W-1:0] dec_ones;
    logic              prom_wr;
    logic [DATA_W-1:0] prom_rdata;

    prom_dec_decode #(.OFS_W(OFS_W)) u_decode (
        .space_mem  (req_mem),
        .io32       (ctl_q.io32),
        .addr       (req_addr),
        .size       (req_size),
        .sel_port   (dec_port),
        .legal      (dec_legal),
        .lane_en    (dec_lanes),
        .width_ones (dec_ones)
    );

    assign prom_wr = req_valid && req_write && dec_legal && !dec_port
                     && ctl_q.prom_we;

    prom_dec_store #(.OFS_W(OFS_W), .DEF_PROM(DEF_PROM)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (prom_wr),
        .base    (req_addr[OFS_W-1:0]),
        .lane_en (dec_lanes),
        .wdata   (req_wdata),
        .rdata   (prom_rdata)
    );

    // Register-port forwarding, same cycle as the host request
    assign rp_valid = req_valid && dec_legal && dec_port;
    assign rp_write = req_write;
    assign rp_addr  = req_addr[OFS_W-1:0];
    assign rp_dword = (req_size == SZ_DWORD);
    assign rp_wdata = req_wdata;

    always_comb begin
        ctl_d           = ctl_q;
        ctl_d.rsp_valid = req_valid && !req_write;
        ctl_d.rsp_rdata = '0;
        if (req_valid && !req_write) begin
            if (!dec_legal) begin
                ctl_d.rsp_rdata = dec_ones;
            end else if (dec_port) begin
                ctl_d.rsp_rdata = rp_rdata & dec_ones;
            end else begin
                ctl_d.rsp_rdata = prom_rdata;
            end
        end
        if (cfg_load) begin
            ctl_d.io32    = cfg_io32;
            ctl_d.prom_we = cfg_prom_we;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rsp_valid = ctl_q.rsp_valid;
    assign rsp_rdata = ctl_q.rsp_rdata;

    // R9
    rsp_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);

    // R9
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rsp_valid);

    // R3
    port_no_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rp_valid |-> (req_size == 2'd1 || req_size == 2'd2));

    // R5
    io32_dword_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.io32 && req_valid && !req_mem && !req_addr[OFS_W] && dec_legal)
        |-> (req_size == 2'd2 && req_addr[1:0] == 2'b00));

    // R7
    reject_byte_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !dec_legal && req_size == 2'd0)
        |=> (rsp_rdata == 32'h0000_00FF));

endmodule

// File: tb/prom_access_decoder_test.sv
module prom_access_decoder_test;

    localparam logic [127:0] DEF = 128'h8877_6655_4433_2211_F0E1_D2C3_B4A5_9687;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load = 1'b0, cfg_io32 = 1'b0, cfg_prom_we = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_mem = 1'b0;
    logic [4:0]  req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, rp_valid, rp_write, rp_dword;
    logic [31:0] rsp_rdata, rp_wdata, rp_rdata;
    logic [3:0]  rp_addr;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] shadow [16];
    logic       m_io32, m_we;

    always #2 clk = ~clk;

    // register-port model: pure function of the offset
    assign rp_rdata = {8'h5A, 4'h0, rp_addr, 8'hC3, 4'h0, rp_addr};

    prom_access_decoder #(.OFS_W(4), .DEF_PROM(DEF)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_io32(cfg_io32),
        .cfg_prom_we(cfg_prom_we), .req_valid(req_valid), .req_write(req_write),
        .req_mem(req_mem), .req_addr(req_addr), .req_size(req_size),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rp_valid(rp_valid), .rp_write(rp_write), .rp_addr(rp_addr),
        .rp_dword(rp_dword), .rp_wdata(rp_wdata), .rp_rdata(rp_rdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit legal_of(bit mem, bit io32, logic [4:0] a, logic [1:0] s);
        if (a[4])       return (s == 2'd1) || (s == 2'd2);
        else if (mem)   return (s != 2'd3);
        else if (io32)  return (s == 2'd2) && (a[1:0] == 2'b00);
        else            return (s == 2'd0) || ((s == 2'd1) && !a[0]);
    endfunction

    function automatic logic [31:0] ones_of(logic [1:0] s);
        case (s)
            2'd0:    return 32'h0000_00FF;
            2'd1:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic string tag_of(bit mem, bit io32, logic [4:0] a, logic [1:0] s);
        if (!legal_of(mem, io32, a, s)) return "R7";
        if (a[4])       return mem ? "R8/R10" : "R3/R10";
        if (mem)        return "R8";
        if (s != 2'd0)  return io32 ? "R5/R6" : "R4/R6";
        return "R4";
    endfunction

    task automatic set_mode(input bit io32, input bit we);
        @(negedge clk);
        cfg_load = 1'b1; cfg_io32 = io32; cfg_prom_we = we;
        @(negedge clk);
        cfg_load = 1'b0;
        m_io32 = io32; m_we = we;
    endtask

    task automatic do_read(input bit mem, input logic [4:0] a, input logic [1:0] s);
        logic [31:0] exp;
        bit lg;
        string t;
        lg = legal_of(mem, m_io32, a, s);
        t  = tag_of(mem, m_io32, a, s);
        if (!lg) exp = ones_of(s);
        else if (a[4]) exp = {8'h5A, 4'h0, a[3:0], 8'hC3, 4'h0, a[3:0]} & ones_of(s);
        else begin
            exp = '0;
            for (int k = 0; k < 4; k++)
                if (ones_of(s)[8*k]) exp[8*k +: 8] = shadow[(int'(a[3:0]) + k) % 16];
        end
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_mem = mem; req_addr = a; req_size = s;
        #1;
        // R10 forwarding in the request cycle
        chk(rp_valid == (lg && a[4]), {t, " rp_valid"}, 32'(rp_valid), 32'(lg && a[4]));
        if (lg && a[4]) begin
            chk(rp_addr == a[3:0] && rp_dword == (s == 2'd2) && !rp_write,
                "R10 rd fwd", {27'b0, rp_write, rp_addr}, {28'b0, a[3:0]});
        end
        @(negedge clk);
        req_valid = 1'b0;
        // R9 response pulse
        chk(rsp_valid == 1'b1, "R9 rsp_valid", 32'(rsp_valid), 32'd1);
        chk(rsp_rdata == exp, {t, " rdata"}, rsp_rdata, exp);
    endtask

    task automatic do_write(input bit mem, input logic [4:0] a, input logic [1:0] s,
                            input logic [31:0] d);
        bit lg;
        string t;
        lg = legal_of(mem, m_io32, a, s);
        t  = tag_of(mem, m_io32, a, s);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_mem = mem; req_addr = a;
        req_size = s; req_wdata = d;
        #1;
        chk(rp_valid == (lg && a[4]), {t, " wr rp_valid"}, 32'(rp_valid), 32'(lg && a[4]));
        if (lg && a[4]) begin
            chk(rp_write && rp_addr == a[3:0] && rp_dword == (s == 2'd2) && rp_wdata == d,
                "R10 wr fwd", rp_wdata, d);
        end
        // R2 shadow update only with write-enable
        if (lg && !a[4] && m_we) begin
            for (int k = 0; k < 4; k++)
                if (ones_of(s)[8*k]) shadow[(int'(a[3:0]) + k) % 16] = d[8*k +: 8];
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid == 1'b0, "R9 no rsp on write", 32'(rsp_valid), 32'd0);
    endtask

    task automatic readback(input string t);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            req_valid = 1'b1; req_write = 1'b0; req_mem = 1'b1;
            req_addr = 5'(i); req_size = 2'd0;
            @(negedge clk);
            req_valid = 1'b0;
            chk(rsp_rdata == {24'b0, shadow[i]}, t, rsp_rdata, {24'b0, shadow[i]});
        end
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=0", n_chk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) shadow[i] = DEF[8*i +: 8];
        m_io32 = 1'b0; m_we = 1'b0;
        repeat (3) @(negedge clk);
        chk(rsp_valid == 1'b0, "R1 rsp_valid in reset", 32'(rsp_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
        // R1: default contents, narrow mode (I/O bytes accepted)
        for (int i = 0; i < 16; i++) do_read(1'b0, 5'(i), 2'd0);
        // R1 / R2: write-enable clear after reset, write dropped
        do_write(1'b0, 5'd3, 2'd0, 32'h0000_00EE);
        readback("R1/R2 write-enable clear after reset");

        for (int m = 0; m < 4; m++) begin
            // R11 mode load
            set_mode(m[0], m[1]);
            for (int sp = 0; sp < 2; sp++)
                for (int s = 0; s < 4; s++)
                    for (int a = 0; a < 32; a++)
                        do_read(sp[0], 5'(a), 2'(s));
            for (int sp = 0; sp < 2; sp++)
                for (int s = 0; s < 4; s++)
                    for (int a = 0; a < 32; a++)
                        do_write(sp[0], 5'(a), 2'(s),
                                 {8'(a * 7 + s), 8'(a + 64), 8'(m * 16 + a), 8'(a ^ 165)});
            readback("R2/R7/R11 store contents after write sweep");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule